// File: doc/BRIEF.md
# Peripheral Protection Attribute Checker

This block guards a peripheral region. For every protection context of the chip it keeps five permission bits: user read, user write, privileged read, privileged write, and non-secure access. Software programs these bits through a small word-addressed configuration port. That port accepts writes only while a separate master-permission input allows them. Context 0 is wired to full access and cannot be restricted.

Each bus access that targets the region is presented as a query. The query carries the requesting context, its privilege level, its direction and its security state. In the same cycle the block answers allow or deny, using nothing but the stored bits.

The parameter `NUM_CTX` (1 to 16) sets how many contexts exist. Storage is built only for those contexts. The permission words that hold them are present, and every other word or lane reads as zero.

Top module: `prot_attr_guard`

## Requirements
- R1: Context c is held in word c/4, byte lane c%4 (bits 8*(c%4)+7 down to 8*(c%4)). Within a lane, bit 0 is user read, bit 1 is user write, bit 2 is privileged read, bit 3 is privileged write and bit 4 is non-secure. Bits 7:5 of every lane always read 0.
- R2: The lane of context 0 always reads 0x1F and ignores writes. A query from context 0 is always allowed.
- R3: After reset, every lane of a present context reads 0x1F.
- R4: The number of present words is ceil(NUM_CTX/4), at word addresses 0 upward. A read of a word address at or beyond that count returns 0, and a write to it has no effect.
- R5: Lanes for contexts at or above NUM_CTX inside a present word read 0 and ignore writes.
- R6: For a secure query (q_ns=0), q_allow equals the selected bit of the requesting context: user read when q_priv=0 and q_write=0, user write when q_priv=0 and q_write=1, privileged read when q_priv=1 and q_write=0, privileged write when q_priv=1 and q_write=1.
- R7: A non-secure query (q_ns=1) is allowed only if the selected bit and the context's non-secure bit are both 1. The non-secure bit has no effect on secure queries.
- R8: A configuration write (cfg_valid=1, cfg_write=1) changes stored bits only when cfg_wr_allowed=1.
- R9: A query whose q_ctx is NUM_CTX or greater is always denied.
- R10: cfg_rdata is 0 after reset. It takes the addressed word at the clock edge that accepts a read (cfg_valid=1, cfg_write=0) and holds at all other edges. A write becomes visible to queries and reads from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 2 | Permission word index |
| cfg_wdata | input | 32 | Write data |
| cfg_wr_allowed | input | 1 | Master permission for configuration writes |
| cfg_rdata | output | 32 | Registered read data |
| q_ctx | input | 4 | Requesting protection context |
| q_priv | input | 1 | Query is privileged |
| q_write | input | 1 | Query is a write |
| q_ns | input | 1 | Query is non-secure |
| q_allow | output | 1 | Combinational access verdict |

## Verification
The hardest case to reach from the ports is the edge of the context count. That means the partly filled last word, whose upper lanes have no storage, and the word addresses past it. The default count of 16 fills every lane, so the bench builds the block with 10 contexts. It then writes all-ones and random patterns to every word address, including the absent one, with the master permission both set and clear. After each write it reads the words back and sweeps queries across all 16 context IDs and all eight kinds of access.

// File: rtl/pag_pkg.sv
`timescale 1ns/1ps
package pag_pkg;

    localparam int MAX_CTX   = 16;
    localparam int LANES     = 4;
    localparam int LANE_W    = 8;
    localparam int WORD_W    = LANES * LANE_W;
    localparam int CTX_W     = $clog2(MAX_CTX);
    localparam int MAX_WORDS = MAX_CTX / LANES;
    localparam int ADDR_W    = $clog2(MAX_WORDS);
    localparam int PERM_W    = 5;

    typedef struct packed {
        logic ns;
        logic pw;
        logic pr;
        logic uw;
        logic ur;
    } ctx_perm_t;

    localparam ctx_perm_t PERM_ALL  = '{ns: 1'b1, pw: 1'b1, pr: 1'b1, uw: 1'b1, ur: 1'b1};
    localparam ctx_perm_t PERM_NONE = '{ns: 1'b0, pw: 1'b0, pr: 1'b0, uw: 1'b0, ur: 1'b0};

    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic             priv;
        logic             write;
        logic             ns;
    } access_req_t;

    function automatic logic [LANE_W-1:0] lane_image(ctx_perm_t p);
        return {{(LANE_W-PERM_W){1'b0}}, p};
    endfunction

    function automatic ctx_perm_t lane_extract(logic [LANE_W-1:0] b);
        return ctx_perm_t'(b[PERM_W-1:0]);
    endfunction

    function automatic logic perm_grants(ctx_perm_t p, access_req_t r);
        logic kind_ok;
        unique case ({r.priv, r.write})
            2'b00:   kind_ok = p.ur;
            2'b01:   kind_ok = p.uw;
            2'b10:   kind_ok = p.pr;
            default: kind_ok = p.pw;
        endcase
        return kind_ok & (~r.ns | p.ns);
    endfunction

endpackage

// File: rtl/pag_ctx_reg.sv
`timescale 1ns/1ps
module pag_ctx_reg
    import pag_pkg::*;
#(
    parameter bit FIXED = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  ctx_perm_t wr_perm,
    output ctx_perm_t perm
);

    generate
        if (FIXED) begin : g_fixed
            logic unused_fixed;
            assign unused_fixed = ^{clk, rst, wr_en, wr_perm};
            assign perm = PERM_ALL;
        end else begin : g_store
            ctx_perm_t perm_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    perm_q <= PERM_ALL;
                end else if (wr_en) begin
                    perm_q <= wr_perm;
                end
            end
            assign perm = perm_q;
        end
    endgenerate

endmodule

// File: rtl/pag_read_port.sv
`timescale 1ns/1ps
module pag_read_port
    import pag_pkg::*;
#(
    parameter int NUM_CTX = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    input  logic [MAX_CTX*LANE_W-1:0]   image,
    output logic [WORD_W-1:0]           rdata
);

    localparam int NUM_WORDS = (NUM_CTX + LANES - 1) / LANES;

    logic [WORD_W-1:0] word_sel;

    always_comb begin
        if (int'(rd_addr) < NUM_WORDS) begin
            word_sel = image[rd_addr*WORD_W +: WORD_W];
        end else begin
            word_sel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= word_sel;
        end
    end

endmodule

// File: rtl/pag_access_judge.sv
`timescale 1ns/1ps
module pag_access_judge
    import pag_pkg::*;
#(
    parameter int NUM_CTX = 16
) (
    input  ctx_perm_t [MAX_CTX-1:0] perms,
    input  access_req_t             req,
    output logic                    allow
);

    ctx_perm_t sel_perm;
    logic      ctx_present;

    always_comb begin
        ctx_present = int'(req.ctx) < NUM_CTX;
        sel_perm    = perms[req.ctx];
        allow       = ctx_present & perm_grants(sel_perm, req);
    end

endmodule

// File: rtl/prot_attr_guard.sv
`timescale 1ns/1ps
module prot_attr_guard
    import pag_pkg::*;
#(
    parameter int NUM_CTX = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_wr_allowed,
    output logic [31:0]       cfg_rdata,
    input  logic [3:0]        q_ctx,
    input  logic              q_priv,
    input  logic              q_write,
    input  logic              q_ns,
    output logic              q_allow
);

    localparam int NUM_WORDS = (NUM_CTX + LANES - 1) / LANES;

    ctx_perm_t [MAX_CTX-1:0]     perm_all;
    logic [MAX_CTX*LANE_W-1:0]   image;
    logic                        wr_go;
    access_req_t                 req;

    assign wr_go = cfg_valid & cfg_write & cfg_wr_allowed;

    generate
        for (genvar c = 0; c < MAX_CTX; c++) begin : g_ctx
            if (c < NUM_CTX) begin : g_present
                logic word_hit;
                assign word_hit = (cfg_addr == ADDR_W'(c / LANES));
                pag_ctx_reg #(.FIXED(c == 0)) u_reg (
                    .clk     (clk),
                    .rst     (rst),
                    .wr_en   (wr_go & word_hit),
                    .wr_perm (lane_extract(cfg_wdata[(c % LANES)*LANE_W +: LANE_W])),
                    .perm    (perm_all[c])
                );
            end else begin : g_absent
                assign perm_all[c] = PERM_NONE;
            end
            assign image[c*LANE_W +: LANE_W] = lane_image(perm_all[c]);
        end
    endgenerate

    pag_read_port #(.NUM_CTX(NUM_CTX)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (cfg_valid & ~cfg_write),
        .rd_addr (cfg_addr),
        .image   (image),
        .rdata   (cfg_rdata)
    );

    assign req = '{ctx: q_ctx, priv: q_priv, write: q_write, ns: q_ns};

    pag_access_judge #(.NUM_CTX(NUM_CTX)) u_judge (
        .perms (perm_all),
        .req   (req),
        .allow (q_allow)
    );

    if (NUM_WORDS > MAX_WORDS) begin : g_bad_param
        initial $error("NUM_CTX exceeds supported range");
    end

endmodule

// File: rtl/pag_checker.sv
`timescale 1ns/1ps
module pag_checker #(
    parameter int NUM_CTX = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_valid,
    input logic        cfg_write,
    input logic [1:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic [3:0]  q_ctx,
    input logic        q_allow
);

    localparam int NUM_WORDS = (NUM_CTX + 3) / 4;

    AST_ROOT_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (q_ctx == 4'd0) |-> q_allow); // R2

    AST_ROOT_READBACK: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_write && cfg_addr == 2'd0) |=> (cfg_rdata[4:0] == 5'h1F)); // R2

    AST_OUT_OF_RANGE_DENIED: assert property (@(posedge clk) disable iff (rst)
        (int'(q_ctx) >= NUM_CTX) |-> !q_allow); // R9

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[7:5] == 3'b0 && cfg_rdata[15:13] == 3'b0 &&
         cfg_rdata[23:21] == 3'b0 && cfg_rdata[31:29] == 3'b0)); // R1

    AST_ABSENT_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !cfg_write && int'(cfg_addr) >= NUM_WORDS) |=> (cfg_rdata == 32'h0)); // R4

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(cfg_valid && !cfg_write) |=> $stable(cfg_rdata)); // R10

endmodule

bind prot_attr_guard pag_checker #(.NUM_CTX(NUM_CTX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cfg_write (cfg_write),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .q_ctx     (q_ctx),
    .q_allow   (q_allow)
);

// File: tb/sim_prot_attr_guard.sv
`timescale 1ns/1ps
module sim_prot_attr_guard;

    localparam int NC = 10;
    localparam int NW = (NC + 3) / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_valid = 1'b0;
    logic        cfg_write = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_wr_allowed = 1'b0;
    logic [31:0] cfg_rdata;
    logic [3:0]  q_ctx = '0;
    logic        q_priv = 1'b0;
    logic        q_write = 1'b0;
    logic        q_ns = 1'b0;
    logic        q_allow;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [4:0]  model [16];
    logic [31:0] exp_rdata;

    always #5 clk = ~clk;

    prot_attr_guard #(.NUM_CTX(NC)) u0 (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_write(cfg_write),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wr_allowed(cfg_wr_allowed),
        .cfg_rdata(cfg_rdata), .q_ctx(q_ctx), .q_priv(q_priv), .q_write(q_write),
        .q_ns(q_ns), .q_allow(q_allow)
    );

    function automatic logic [31:0] model_word(int a);
        logic [31:0] w = '0;
        if (a >= NW) return w;
        for (int l = 0; l < 4; l++) begin
            int c = a * 4 + l;
            if (c < NC) w[8*l +: 8] = {3'b000, model[c]};
        end
        return w;
    endfunction

    function automatic logic model_allow(int c, logic p, logic w, logic n);
        logic b;
        if (c >= NC) return 1'b0;
        case ({p, w})
            2'b00:   b = model[c][0];
            2'b01:   b = model[c][1];
            2'b10:   b = model[c][2];
            default: b = model[c][3];
        endcase
        if (n) b = b & model[c][4];
        return b;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 16; c++) model[c] = (c < NC) ? 5'h1F : 5'h00;
        exp_rdata = '0;
    endtask

    task automatic step(input string tag, input bit v, input bit w, input bit [1:0] a,
                        input bit [31:0] d, input bit ok, input bit [3:0] c,
                        input bit p, input bit wr, input bit n);
        logic  ea;
        string qtag;
        cfg_valid = v; cfg_write = w; cfg_addr = a; cfg_wdata = d; cfg_wr_allowed = ok;
        q_ctx = c; q_priv = p; q_write = wr; q_ns = n;
        #1;
        ea = model_allow(int'(c), p, wr, n);
        if (int'(c) >= NC)  qtag = "R9";
        else if (c == 0)    qtag = "R2";
        else if (n)         qtag = "R7";
        else                qtag = "R6";
        vectors++;
        if (q_allow !== ea) begin
            miscompares++;
            $display("FAIL %s q_allow ctx=%0d priv=%0b wr=%0b ns=%0b actual=%0b expected=%0b",
                     qtag, c, p, wr, n, q_allow, ea);
        end
        @(posedge clk);
        if (v && !w) exp_rdata = model_word(int'(a));
        if (v && w && ok && int'(a) < NW) begin
            for (int l = 0; l < 4; l++) begin
                int cc = int'(a) * 4 + l;
                if (cc != 0 && cc < NC) model[cc] = d[8*l +: 5];
            end
        end
        @(negedge clk);
        vectors++;
        if (cfg_rdata !== exp_rdata) begin
            miscompares++;
            $display("FAIL %s cfg_rdata actual=%08h expected=%08h", tag, cfg_rdata, exp_rdata);
        end
    endtask

    task automatic rd(input string tag, input bit [1:0] a);
        step(tag, 1'b1, 1'b0, a, 32'h0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic wr(input string tag, input bit [1:0] a, input bit [31:0] d, input bit ok);
        step(tag, 1'b1, 1'b1, a, d, ok, 4'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic sweep(input string tag);
        for (int c = 0; c < 16; c++)
            for (int k = 0; k < 8; k++)
                step(tag, 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'(c), k[2], k[1], k[0]);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        vectors++;
        if (cfg_rdata !== 32'h0) begin
            miscompares++;
            $display("FAIL R10 reset cfg_rdata actual=%08h expected=00000000", cfg_rdata);
        end
        // R3 reset contents, R4 absent word, R5 partial word
        rd("R3", 2'd0); rd("R3", 2'd1); rd("R5", 2'd2); rd("R4", 2'd3);
        sweep("R6");
        // R8 locked write
        wr("R8", 2'd1, 32'h0, 1'b0); rd("R8", 2'd1);
        // R2 root lane fixed
        wr("R2", 2'd0, 32'h0, 1'b1); rd("R2", 2'd0);
        // R5 absent lanes in last word
        wr("R5", 2'd2, 32'hFFFF_FFFF, 1'b1); rd("R5", 2'd2);
        // R4 absent word
        wr("R4", 2'd3, 32'hFFFF_FFFF, 1'b1); rd("R4", 2'd3);
        // R1 lane layout with distinct patterns
        wr("R1", 2'd1, 32'h0F1E_1311, 1'b1); rd("R1", 2'd1);
        wr("R1", 2'd0, 32'hE817_0402, 1'b1); rd("R1", 2'd0);
        wr("R1", 2'd2, 32'h0000_1508, 1'b1); rd("R10", 2'd2);
        sweep("R7");
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 3);
            if (op == 0) wr("R8", 2'($urandom), $urandom, 1'($urandom));
            else if (op == 1) rd("R1", 2'($urandom));
            else step("R10", 1'b0, 1'b0, 2'd0, 32'h0, 1'b0, 4'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom));
        end
        sweep("R6");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule